// File: doc/BRIEF.md
# Bus Master Sequencing Controller

This block sequences the bus cycles of a simple master that stands in for a processor. A program counter selects one word of a small command table. Each word holds an address and a control code. For every word the controller asks for the bus, waits for the grant, drives the word onto the bus, and waits for the target to acknowledge. It then advances the counter. The master only writes out commands and never reads data back.

Between bus cycles the controller checks an interrupt line. A pending interrupt is acknowledged through a fixed four-state acknowledge sequence. That sequence then merges back into the end-of-cycle state of the main loop.

The sequencer has twelve states. Their codes are chosen so that every legal transition flips exactly one state bit, which keeps the decoded outputs free of glitches. Interrupts are looked at in two places only: the check state at the top of each cycle and the settle state at its end. When an interrupt is seen in the settle state, the machine goes through one bridge state before it enters the acknowledge sequence.

Top module: `bus_master_ctl`

## Requirements
- R1: While `rst_n` is low the machine sits in the idle state (code 4'b0010) with `bus_req`, `bus_drv_en`, `irq_ack` and `pc_step` low and `pc_value` zero. Assertion takes effect at once. After release the idle state is left for the check state once the internal reset has been released on the clock.
- R2: The state codes are: idle 0010, check 0000, request 0001, drive 0011, release 0111, count 0110, settle 0100, bridge 1100, acknowledge steps 1000, 1001, 1101, 0101. Every transition changes exactly one bit of `state_code`.
- R3: In the check state, `irq` high leads to the first acknowledge step; `irq` low leads to the request state.
- R4: In the request state only `bus_req` is high. The machine stays there until `bus_gnt` is seen high, then moves to drive.
- R5: In the drive state `bus_req` and `bus_drv_en` are both high, and `bus_addr`/`bus_ctrl` carry the table word at `pc_value`. The machine stays in drive until `slave_ack` is high. Whenever `bus_drv_en` is low, `bus_addr` and `bus_ctrl` are zero.
- R6: The release state drives nothing and waits for `slave_ack` to go low. The count state then raises `pc_step` for exactly one cycle, and `pc_value` advances at the end of that cycle.
- R7: A cycle without an interrupt visits check, request, drive, release, count, settle and returns to check.
- R8: `irq_ack` is high only in the four acknowledge steps, which run in order. The last step waits for `irq` to drop and then goes to settle. `bus_req` is never high together with `irq_ack`.
- R9: In the settle state, `irq` high leads to the bridge state and then to the first acknowledge step; `irq` low leads to the check state.
- R10: Table word k holds address 8'h10 + 4·k and control code (k mod 3) + 1. The counter wraps from ROM_DEPTH−1 (4 by default) to 0.
- R11: `irq` has no effect on the path while the machine is in the request, drive, release or count states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| slave_ack | input | 1 | Acknowledge from the addressed target |
| irq | input | 1 | Interrupt request |
| bus_req | output | 1 | Bus request |
| bus_drv_en | output | 1 | Enable for driving address and control |
| irq_ack | output | 1 | Interrupt acknowledge |
| pc_step | output | 1 | One-cycle program counter advance |
| bus_addr | output | ADDR_W | Address driven onto the bus, zero when not driving |
| bus_ctrl | output | CTRL_W | Control code driven onto the bus, zero when not driving |
| pc_value | output | PC_W | Current program counter |
| state_code | output | 4 | Registered sequencer state |

## Verification
The hardest route to reach is the path from settle into the acknowledge sequence through the bridge state. `irq` has to rise after the check state has passed and be held high at the single edge where settle samples it. To get there, the stimulus raises `irq` while the machine is in the count state and keeps it high until the last acknowledge step. A second scenario raises `irq` during request and lowers it in count, which shows that the line is ignored mid-cycle. Each step is compared against the exact expected code, and a monitor counts state-bit flips on every cycle.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [3:0] {
    S_IDLE    = 4'b0010,
    S_CHECK   = 4'b0000,
    S_REQ     = 4'b0001,
    S_DRIVE   = 4'b0011,
    S_RELEASE = 4'b0111,
    S_COUNT   = 4'b0110,
    S_SETTLE  = 4'b0100,
    S_BRIDGE  = 4'b1100,
    S_ACK0    = 4'b1000,
    S_ACK1    = 4'b1001,
    S_ACK2    = 4'b1101,
    S_ACK3    = 4'b0101
  } seq_state_t;
endpackage

// File: rtl/bmc_rst_sync.sv
module bmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/bmc_seq_fsm.sv
module bmc_seq_fsm
  import bmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_gnt,
  input  logic       slave_ack,
  input  logic       irq,
  output logic       bus_req,
  output logic       bus_drv_en,
  output logic       irq_ack,
  output logic       pc_step,
  output logic [3:0] state_code
);
  seq_state_t state_q, state_d;

  // next-state decode
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    state_d = S_CHECK;
      S_CHECK:   state_d = irq ? S_ACK0 : S_REQ;
      S_REQ:     state_d = bus_gnt ? S_DRIVE : S_REQ;
      S_DRIVE:   state_d = slave_ack ? S_RELEASE : S_DRIVE;
      S_RELEASE: state_d = slave_ack ? S_RELEASE : S_COUNT;
      S_COUNT:   state_d = S_SETTLE;
      S_SETTLE:  state_d = irq ? S_BRIDGE : S_CHECK;
      S_BRIDGE:  state_d = S_ACK0;
      S_ACK0:    state_d = S_ACK1;
      S_ACK1:    state_d = S_ACK2;
      S_ACK2:    state_d = S_ACK3;
      S_ACK3:    state_d = irq ? S_ACK3 : S_SETTLE;
      default:   state_d = S_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // Moore output decode
  always_comb begin
    bus_req    = (state_q == S_REQ) || (state_q == S_DRIVE);
    bus_drv_en = (state_q == S_DRIVE);
    irq_ack    = (state_q == S_ACK0) || (state_q == S_ACK1) ||
                 (state_q == S_ACK2) || (state_q == S_ACK3);
    pc_step    = (state_q == S_COUNT);
  end

  assign state_code = state_q;

  // R2
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q ^ $past(state_q)) <= 1);

  // R4
  grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_REQ && !bus_gnt) |=> (state_q == S_REQ));

  // R5
  drive_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drv_en |-> bus_req);

  // R6
  step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |=> !pc_step);

  // R8
  ack_excl_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !bus_req);

  // R9
  bridge_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BRIDGE) |=> irq_ack);
endmodule

// File: rtl/bmc_pc.sv
module bmc_pc #(
  parameter int DEPTH = 5,
  parameter int PC_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] LAST = PC_W'(DEPTH - 1);

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (step) pc_d = (pc_q == LAST) ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (step) pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q));

  // R10
  pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= LAST);
endmodule

// File: rtl/bmc_cmd_rom.sv
module bmc_cmd_rom #(
  parameter int DEPTH     = 5,
  parameter int PC_W      = 3,
  parameter int AW        = 8,
  parameter int CW        = 2,
  parameter int ADDR_BASE = 16,
  parameter int ADDR_STEP = 4
) (
  input  logic [PC_W-1:0] pc,
  output logic [AW-1:0]   addr,
  output logic [CW-1:0]   ctrl
);
  logic [AW-1:0] tbl_addr [DEPTH];
  logic [CW-1:0] tbl_ctrl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign tbl_addr[g] = AW'(ADDR_BASE + g * ADDR_STEP);
    assign tbl_ctrl[g] = CW'((g % 3) + 1);
  end

  always_comb begin
    addr = '0;
    ctrl = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (pc == PC_W'(k)) begin
        addr = tbl_addr[k];
        ctrl = tbl_ctrl[k];
      end
    end
  end
endmodule

// File: rtl/bus_master_ctl.sv
module bus_master_ctl #(
  parameter int ROM_DEPTH = 5,
  parameter int ADDR_W    = 8,
  parameter int CTRL_W    = 2,
  parameter int ADDR_BASE = 16,
  parameter int ADDR_STEP = 4,
  parameter int PC_W      = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_gnt,
  input  logic              slave_ack,
  input  logic              irq,
  output logic              bus_req,
  output logic              bus_drv_en,
  output logic              irq_ack,
  output logic              pc_step,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CTRL_W-1:0] bus_ctrl,
  output logic [PC_W-1:0]   pc_value,
  output logic [3:0]        state_code
);
  logic              rst_n_int;
  logic [ADDR_W-1:0] rom_addr;
  logic [CTRL_W-1:0] rom_ctrl;

  bmc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_int)
  );

  bmc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int), .bus_gnt(bus_gnt), .slave_ack(slave_ack),
    .irq(irq), .bus_req(bus_req), .bus_drv_en(bus_drv_en),
    .irq_ack(irq_ack), .pc_step(pc_step), .state_code(state_code)
  );

  bmc_pc #(.DEPTH(ROM_DEPTH), .PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n_int), .step(pc_step), .pc(pc_value)
  );

  bmc_cmd_rom #(
    .DEPTH(ROM_DEPTH), .PC_W(PC_W), .AW(ADDR_W), .CW(CTRL_W),
    .ADDR_BASE(ADDR_BASE), .ADDR_STEP(ADDR_STEP)
  ) u_rom (
    .pc(pc_value), .addr(rom_addr), .ctrl(rom_ctrl)
  );

  // drive gate standing in for a three-state buffer
  assign bus_addr = bus_drv_en ? rom_addr : '0;
  assign bus_ctrl = bus_drv_en ? rom_ctrl : '0;

  // R5
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !bus_req |-> (bus_addr == '0));
endmodule

// File: tb/test_bus_master_ctl.sv
module test_bus_master_ctl;
  localparam int DEPTH = 5;
  localparam int PCW   = 3;

  localparam logic [3:0] C_IDLE = 4'b0010, C_CHECK = 4'b0000, C_REQ = 4'b0001,
    C_DRIVE = 4'b0011, C_REL = 4'b0111, C_CNT = 4'b0110, C_SETTLE = 4'b0100,
    C_BRIDGE = 4'b1100, C_A0 = 4'b1000, C_A1 = 4'b1001, C_A2 = 4'b1101,
    C_A3 = 4'b0101;

  logic clk = 1'b0;
  logic rst_n, bus_gnt, slave_ack, irq;
  logic bus_req, bus_drv_en, irq_ack, pc_step;
  logic [7:0] bus_addr;
  logic [1:0] bus_ctrl;
  logic [PCW-1:0] pc_value;
  logic [3:0] state_code;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_pc  = 0;
  int flip_viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_master_ctl i_bus_master_ctl (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .slave_ack(slave_ack),
    .irq(irq), .bus_req(bus_req), .bus_drv_en(bus_drv_en), .irq_ack(irq_ack),
    .pc_step(pc_step), .bus_addr(bus_addr), .bus_ctrl(bus_ctrl),
    .pc_value(pc_value), .state_code(state_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_state(input logic [3:0] code, input string tag);
    @(negedge clk);
    check(state_code == code, tag, state_code, code);
  endtask

  function automatic int rom_addr(input int k);
    return (16 + 4 * k) & 8'hff;
  endfunction

  function automatic int rom_ctrl(input int k);
    return (k % 3) + 1;
  endfunction

  // R2 monitor: count samples where more than one state bit flipped
  logic [3:0] prev_state;
  bit prev_ok = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_ok && ($countones(state_code ^ prev_state) > 1)) flip_viol++;
    prev_ok    <= rst_n;
    prev_state <= state_code;
  end

  task automatic wait_check_state(input string tag);
    bit seen = 1'b0;
    for (int n = 0; n < 8 && !seen; n++) begin
      @(negedge clk);
      if (state_code == C_CHECK) seen = 1'b1;
      else check(state_code == C_IDLE, {tag, " idle before check"}, state_code, C_IDLE);
    end
    check(seen, {tag, " reached check"}, seen, 1);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0; bus_gnt = 1'b0; slave_ack = 1'b0; irq = 1'b0;
    repeat (3) @(negedge clk);
    check(state_code == C_IDLE, "R1 reset state", state_code, C_IDLE);
    check({bus_req, bus_drv_en, irq_ack, pc_step} == 4'b0, "R1 reset outputs",
          {bus_req, bus_drv_en, irq_ack, pc_step}, 0);
    check(pc_value == 0, "R1 reset pc", pc_value, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(state_code == C_IDLE, "R1 idle after release", state_code, C_IDLE);
    wait_check_state("R1");
    exp_pc = 0;
  endtask

  // single full cycle from check state, fast grant
  task automatic bus_cycle(input string tag);
    bus_gnt = 1'b1;
    expect_state(C_REQ, {tag, " req"});
    expect_state(C_DRIVE, {tag, " drive"});
    check(bus_addr == rom_addr(exp_pc), {tag, " R10 addr"}, bus_addr, rom_addr(exp_pc));
    check(bus_ctrl == rom_ctrl(exp_pc), {tag, " R10 ctrl"}, bus_ctrl, rom_ctrl(exp_pc));
    slave_ack = 1'b1; bus_gnt = 1'b0;
    expect_state(C_REL, {tag, " release"});
    slave_ack = 1'b0;
    expect_state(C_CNT, {tag, " count"});
    expect_state(C_SETTLE, {tag, " settle"});
    exp_pc = (exp_pc == DEPTH - 1) ? 0 : exp_pc + 1;
    check(pc_value == exp_pc, {tag, " R10 pc"}, pc_value, exp_pc);
    expect_state(C_CHECK, {tag, " back to check"});
  endtask

  task automatic t_normal_cycle;
    bus_gnt = 1'b0;
    expect_state(C_REQ, "R7 check->req");
    check(bus_req && !bus_drv_en, "R4 req only", {bus_req, bus_drv_en}, 2'b10);
    expect_state(C_REQ, "R4 wait grant 1");
    expect_state(C_REQ, "R4 wait grant 2");
    bus_gnt = 1'b1;
    expect_state(C_DRIVE, "R7 req->drive");
    check(bus_req && bus_drv_en, "R5 req+en", {bus_req, bus_drv_en}, 2'b11);
    check(bus_addr == rom_addr(exp_pc), "R5 addr", bus_addr, rom_addr(exp_pc));
    check(bus_ctrl == rom_ctrl(exp_pc), "R5 ctrl", bus_ctrl, rom_ctrl(exp_pc));
    bus_gnt = 1'b0;
    expect_state(C_DRIVE, "R5 wait ack");
    slave_ack = 1'b1;
    expect_state(C_REL, "R7 drive->release");
    check(!bus_drv_en && !bus_req, "R6 release drives nothing", {bus_req, bus_drv_en}, 0);
    check(bus_addr == 0 && bus_ctrl == 0, "R5 bus quiet", {bus_addr, bus_ctrl}, 0);
    expect_state(C_REL, "R6 wait ack low");
    slave_ack = 1'b0;
    expect_state(C_CNT, "R7 release->count");
    check(pc_step == 1'b1, "R6 step high", pc_step, 1);
    check(pc_value == exp_pc, "R6 pc before step", pc_value, exp_pc);
    expect_state(C_SETTLE, "R7 count->settle");
    check(pc_step == 1'b0, "R6 step one cycle", pc_step, 0);
    exp_pc = exp_pc + 1;
    check(pc_value == exp_pc, "R6 pc advanced", pc_value, exp_pc);
    expect_state(C_CHECK, "R7 settle->check");
  endtask

  task automatic t_irq_from_check;
    irq = 1'b1;
    expect_state(C_A0, "R3 check->ack0");
    check(irq_ack && !bus_req, "R8 ack0 outputs", {irq_ack, bus_req}, 2'b10);
    expect_state(C_A1, "R8 ack1");
    expect_state(C_A2, "R8 ack2");
    expect_state(C_A3, "R8 ack3");
    check(irq_ack == 1'b1, "R8 ack held", irq_ack, 1);
    expect_state(C_A3, "R8 ack3 waits irq low");
    irq = 1'b0;
    expect_state(C_SETTLE, "R8 rejoin settle");
    check(irq_ack == 1'b0, "R8 ack dropped", irq_ack, 0);
    check(pc_value == exp_pc, "R8 pc unchanged", pc_value, exp_pc);
    expect_state(C_CHECK, "R9 settle->check");
  endtask

  task automatic t_irq_from_settle;
    bus_gnt = 1'b1;
    expect_state(C_REQ, "R9 req");
    expect_state(C_DRIVE, "R9 drive");
    slave_ack = 1'b1; bus_gnt = 1'b0;
    expect_state(C_REL, "R9 release");
    slave_ack = 1'b0;
    expect_state(C_CNT, "R9 count");
    irq = 1'b1;
    expect_state(C_SETTLE, "R9 settle");
    exp_pc = exp_pc + 1;
    expect_state(C_BRIDGE, "R9 settle->bridge");
    check(irq_ack == 1'b0 && bus_req == 1'b0, "R9 bridge quiet", {irq_ack, bus_req}, 0);
    expect_state(C_A0, "R9 bridge->ack0");
    expect_state(C_A1, "R9 ack1");
    expect_state(C_A2, "R9 ack2");
    expect_state(C_A3, "R9 ack3");
    irq = 1'b0;
    expect_state(C_SETTLE, "R9 rejoin settle");
    expect_state(C_CHECK, "R9 back to check");
    check(pc_value == exp_pc, "R9 pc", pc_value, exp_pc);
  endtask

  task automatic t_irq_ignored;
    bus_gnt = 1'b0;
    expect_state(C_REQ, "R11 req");
    irq = 1'b1;
    expect_state(C_REQ, "R11 req held with irq");
    bus_gnt = 1'b1;
    expect_state(C_DRIVE, "R11 drive");
    check(irq_ack == 1'b0, "R11 no ack mid-cycle", irq_ack, 0);
    slave_ack = 1'b1; bus_gnt = 1'b0;
    expect_state(C_REL, "R11 release");
    slave_ack = 1'b0;
    expect_state(C_CNT, "R11 count");
    irq = 1'b0;
    expect_state(C_SETTLE, "R11 settle");
    exp_pc = exp_pc + 1;
    expect_state(C_CHECK, "R11 check");
  endtask

  task automatic t_pc_wrap;
    for (int n = 0; n < DEPTH; n++) bus_cycle("R10 wrap");
  endtask

  task automatic t_async_reset;
    bus_gnt = 1'b1;
    expect_state(C_REQ, "R1 pre-reset req");
    expect_state(C_DRIVE, "R1 pre-reset drive");
    #2 rst_n = 1'b0;
    #1;
    check(state_code == C_IDLE, "R1 async reset state", state_code, C_IDLE);
    check({bus_req, bus_drv_en} == 2'b00, "R1 async reset outputs", {bus_req, bus_drv_en}, 0);
    check(bus_addr == 0 && pc_value == 0, "R1 async reset pc/bus", {bus_addr, pc_value}, 0);
    bus_gnt = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_check_state("R1 re-entry");
    exp_pc = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_normal_cycle();
    t_irq_from_check();
    t_irq_from_settle();
    t_irq_ignored();
    t_pc_wrap();
    t_async_reset();
    bus_cycle("R7 after reset");
    check(flip_viol == 0, "R2 single-bit transitions", flip_viol, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule